// File: doc/BRIEF.md
# Register-Mapped Pin Controller with Interrupt Configuration

This block is a general-purpose pin controller reached through a simple APB-style register port. Bit `i` of every per-pin register belongs to pin `i`. Each pin has the following settings:

- an output value
- a drive direction
- an interrupt enable
- an edge or level sensing choice
- a polarity
- an override that makes an edge-sensed pin react to both edges

Every setting is changed through a pair of write-one strobe words. One word of the pair raises the selected bits and the other lowers them. Bits written as zero are left alone.

Pin inputs pass through a two-stage synchronizer. A third register holds the previous synchronized value, and edges are found by comparing against it. Edge events on edge-sensed pins are latched until software clears them. Level-sensed pins report their synchronized state directly, adjusted for polarity. A single interrupt line is the OR of all enabled status bits. A loopback control feeds the output register into the input path in place of the pins.

Top module: `pin_ctrl_apb`

## Requirements
- R1: After reset these settings are all zero: output, direction, enable, sensing, polarity, any-edge, latched events and loopback. `pin_oe` is 0, `irq` is low, and a read of the control word (byte 0x34) returns 0.
- R2: A read of byte 0x00 returns the synchronized input, which follows `pin_in` two clocks after it is applied. A write to 0x00 sets the output bits written as one and leaves the others unchanged. `pin_out` shows the output register one clock after the write.
- R3: A write to 0x04 clears the output bits written as one. A read of 0x04 returns the per-pin interrupt status.
- R4: Writing ones to 0x08 makes those pins outputs (`pin_oe`=1). Writing ones to 0x0C makes them inputs. A read of either word returns the direction mask.
- R5: Bytes 0x10 and 0x14 set and clear interrupt enables with write-one semantics, and a read of either returns the enable mask. `irq` is high exactly when some pin has both status and enable at 1.
- R6: Writing ones to 0x18 selects edge sensing for those pins, and writing ones to 0x1C selects level sensing. A read of either returns the mask, with 1 meaning edge. The status of a level-sensed pin follows its synchronized input: it is that input when polarity is 1 and its inverse when polarity is 0. It is never latched. With all settings at zero, every pin therefore reads status 1.
- R7: Polarity bits are set through 0x20 and cleared through 0x24, and a read of either returns the mask. An edge-sensed pin with polarity 1 latches on a rising synchronized edge only. With polarity 0 it latches on a falling edge only.
- R8: Any-edge bits are set through 0x28 and cleared through 0x2C, and a read of either returns the mask. An edge-sensed pin with any-edge 1 latches on both edges, whatever its polarity.
- R9: Writing ones to 0x30 clears those latched edge events. An event detected in the same cycle as the clear still latches. A read of 0x30 returns 0.
- R10: Bit 0 of the control word (0x34) enables loopback. While it is set, the input path samples the output register instead of `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 6 | Byte address, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational on paddr |
| pin_in | input | NPINS | Raw pin inputs |
| pin_out | output | NPINS | Output register value |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong setting register shows up on `pin_out` or `pin_oe` in the clock after the write that corrupted it. For sensing and polarity settings, it shows in the read-back of that word. A bad synchronizer depth moves both the status bits and `irq` by a cycle, and the per-clock comparison catches that at the first pin change. A latch that misses, doubles or fails to clear an event leaves `irq` and the status word wrong from the third clock after the pin edge, and it stays wrong until the next clear.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_W = 32;
  localparam int WIDX_W = 4;

  typedef enum logic [WIDX_W-1:0] {
    RG_IN_SET    = 4'd0,
    RG_STAT_CLR  = 4'd1,
    RG_DIR_OUT   = 4'd2,
    RG_DIR_IN    = 4'd3,
    RG_EN_SET    = 4'd4,
    RG_EN_CLR    = 4'd5,
    RG_EDGE      = 4'd6,
    RG_LEVEL     = 4'd7,
    RG_POL_HI    = 4'd8,
    RG_POL_LO    = 4'd9,
    RG_ANY_SET   = 4'd10,
    RG_ANY_CLR   = 4'd11,
    RG_LATCH_CLR = 4'd12,
    RG_CTRL      = 4'd13
  } reg_word_e;

  localparam int CTRL_LOOP_BIT = 0;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic [N-1:0] q_prev
);
  logic [N-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_word,
  input  logic [N-1:0]      wr_data,
  output logic [N-1:0]      out_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      edge_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      any_q,
  output logic              loop_q,
  output logic [N-1:0]      clr_mask
);
  function automatic logic [N-1:0] w1(input logic [N-1:0] cur, input logic [N-1:0] m,
                                      input logic set);
    return set ? (cur | m) : (cur & ~m);
  endfunction

  reg_word_e word;
  assign word     = reg_word_e'(wr_word);
  assign clr_mask = (wr_en && word == RG_LATCH_CLR) ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      en_q   <= '0;
      edge_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
      loop_q <= 1'b0;
    end else if (wr_en) begin
      case (word)
        RG_IN_SET:   out_q  <= w1(out_q, wr_data, 1'b1);
        RG_STAT_CLR: out_q  <= w1(out_q, wr_data, 1'b0);
        RG_DIR_OUT:  dir_q  <= w1(dir_q, wr_data, 1'b1);
        RG_DIR_IN:   dir_q  <= w1(dir_q, wr_data, 1'b0);
        RG_EN_SET:   en_q   <= w1(en_q, wr_data, 1'b1);
        RG_EN_CLR:   en_q   <= w1(en_q, wr_data, 1'b0);
        RG_EDGE:     edge_q <= w1(edge_q, wr_data, 1'b1);
        RG_LEVEL:    edge_q <= w1(edge_q, wr_data, 1'b0);
        RG_POL_HI:   pol_q  <= w1(pol_q, wr_data, 1'b1);
        RG_POL_LO:   pol_q  <= w1(pol_q, wr_data, 1'b0);
        RG_ANY_SET:  any_q  <= w1(any_q, wr_data, 1'b1);
        RG_ANY_CLR:  any_q  <= w1(any_q, wr_data, 1'b0);
        RG_CTRL:     loop_q <= wr_data[CTRL_LOOP_BIT];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] s_cur,
  input  logic [N-1:0] s_prev,
  input  logic [N-1:0] edge_q,
  input  logic [N-1:0] pol_q,
  input  logic [N-1:0] any_q,
  input  logic [N-1:0] en_q,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] ev,
  output logic [N-1:0] lat,
  output logic [N-1:0] status,
  output logic         irq
);
  function automatic logic [N-1:0] edge_hit(input logic [N-1:0] s, input logic [N-1:0] p,
                                            input logic [N-1:0] pol, input logic [N-1:0] any);
    logic [N-1:0] rise, fall;
    rise = s & ~p;
    fall = ~s & p;
    return (any & (rise | fall)) | (~any & pol & rise) | (~any & ~pol & fall);
  endfunction

  function automatic logic [N-1:0] level_act(input logic [N-1:0] s, input logic [N-1:0] pol);
    return ~(s ^ pol);
  endfunction

  assign ev     = edge_hit(s_cur, s_prev, pol_q, any_q) & edge_q;
  assign status = (edge_q & lat) | (~edge_q & level_act(s_cur, pol_q));
  assign irq    = |(status & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= '0;
    else        lat <= ((lat & ~clr_mask) | ev) & edge_q;
  end
endmodule

// File: rtl/pin_ctrl_apb.sv
module pin_ctrl_apb
  import gpio_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = WIDX_W + 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic              wr_en;
  logic [WIDX_W-1:0] wr_word;
  logic [NPINS-1:0]  wr_data;
  logic [NPINS-1:0]  out_q, dir_q, en_q, edge_q, pol_q, any_q, clr_mask;
  logic              loop_q;
  logic [NPINS-1:0]  src, s_cur, s_prev, ev, lat, status;

  assign wr_word = paddr[ADDR_W-1:2];
  assign wr_data = pwdata[NPINS-1:0];
  assign wr_en   = psel && penable && pwrite && (paddr[1:0] == 2'b00);

  generate
    if (NPINS < BUS_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^pwdata[BUS_W-1:NPINS];
    end
  endgenerate

  gpio_regfile #(.N(NPINS)) u_regs (
    .clk(pclk), .rst_n(presetn), .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
    .out_q(out_q), .dir_q(dir_q), .en_q(en_q), .edge_q(edge_q), .pol_q(pol_q),
    .any_q(any_q), .loop_q(loop_q), .clr_mask(clr_mask)
  );

  assign src = loop_q ? out_q : pin_in;

  gpio_sync #(.N(NPINS)) u_sync (
    .clk(pclk), .rst_n(presetn), .d(src), .q(s_cur), .q_prev(s_prev)
  );

  gpio_irq #(.N(NPINS)) u_irq (
    .clk(pclk), .rst_n(presetn), .s_cur(s_cur), .s_prev(s_prev), .edge_q(edge_q),
    .pol_q(pol_q), .any_q(any_q), .en_q(en_q), .clr_mask(clr_mask),
    .ev(ev), .lat(lat), .status(status), .irq(irq)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_comb begin
    case (reg_word_e'(wr_word))
      RG_IN_SET:             prdata = BUS_W'(s_cur);
      RG_STAT_CLR:           prdata = BUS_W'(status);
      RG_DIR_OUT, RG_DIR_IN: prdata = BUS_W'(dir_q);
      RG_EN_SET, RG_EN_CLR:  prdata = BUS_W'(en_q);
      RG_EDGE, RG_LEVEL:     prdata = BUS_W'(edge_q);
      RG_POL_HI, RG_POL_LO:  prdata = BUS_W'(pol_q);
      RG_ANY_SET, RG_ANY_CLR: prdata = BUS_W'(any_q);
      RG_CTRL:               prdata = BUS_W'(loop_q);
      default:               prdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_chk.sv
module gpio_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [3:0]   wr_word,
  input logic [N-1:0] wr_data,
  input logic [N-1:0] out_q,
  input logic [N-1:0] dir_q,
  input logic [N-1:0] en_q,
  input logic [N-1:0] edge_q,
  input logic [N-1:0] lat,
  input logic [N-1:0] ev,
  input logic [N-1:0] clr_mask,
  input logic         irq
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (dir_q == '0 && en_q == '0 && out_q == '0 && !irq));

  a_r2_set_adds_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word == 4'd0) |=> ((out_q & $past(wr_data)) == $past(wr_data)));

  a_r4_dir_out_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word == 4'd2) |=> ((dir_q & $past(wr_data)) == $past(wr_data)));

  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  a_r6_level_unlatched: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q == $past(edge_q)) |-> ((lat & ~edge_q) == '0));

  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |=> ((lat & $past(clr_mask & ~ev)) == '0));
endmodule

bind pin_ctrl_apb gpio_chk #(.N(NPINS)) u_chk (
  .clk(pclk), .rst_n(presetn), .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
  .out_q(out_q), .dir_q(dir_q), .en_q(en_q), .edge_q(edge_q), .lat(lat), .ev(ev),
  .clr_mask(clr_mask), .irq(irq)
);

// File: tb/tb_pin_ctrl_apb.sv
module tb_pin_ctrl_apb;
  localparam int N = 8;

  logic        pclk = 1'b0, presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [5:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [N-1:0] pin_in = '0, pin_out, pin_oe;
  logic        irq;

  int checks = 0, fails = 0;

  pin_ctrl_apb #(.NPINS(N)) dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #5 pclk = ~pclk;

  // behavioural reference model
  bit [N-1:0] m_out, m_dir, m_en, m_edge, m_pol, m_any, m_lat;
  bit         m_loop;
  bit [N-1:0] hist[$];

  function automatic bit [N-1:0] m_status();
    bit [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (m_edge[i]) r[i] = m_lat[i];
      else           r[i] = m_pol[i] ? hist[1][i] : !hist[1][i];
    end
    return r;
  endfunction

  function automatic bit [31:0] m_read(int w);
    case (w)
      0: return 32'(hist[1]);
      1: return 32'(m_status());
      2, 3: return 32'(m_dir);
      4, 5: return 32'(m_en);
      6, 7: return 32'(m_edge);
      8, 9: return 32'(m_pol);
      10, 11: return 32'(m_any);
      13: return 32'(m_loop);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge pclk) begin
    if (!presetn) begin
      m_out = 0; m_dir = 0; m_en = 0; m_edge = 0; m_pol = 0; m_any = 0; m_lat = 0; m_loop = 0;
      hist = '{0, 0, 0};
    end else begin
      bit wr;
      int w;
      bit [N-1:0] d, clr;
      wr = psel && penable && pwrite && paddr[1:0] == 2'b00;
      w = int'(paddr[5:2]);
      d = pwdata[N-1:0];
      clr = (wr && w == 12) ? d : '0;
      for (int i = 0; i < N; i++) begin
        bit now, was, hit;
        now = hist[1][i]; was = hist[2][i];
        if (m_any[i])      hit = now != was;
        else if (m_pol[i]) hit = now && !was;
        else               hit = !now && was;
        if (!m_edge[i])    m_lat[i] = 0;
        else if (hit)      m_lat[i] = 1;
        else if (clr[i])   m_lat[i] = 0;
      end
      hist.push_front(m_loop ? m_out : pin_in);
      void'(hist.pop_back());
      if (wr) begin
        case (w)
          0: m_out |= d;   1: m_out &= ~d;
          2: m_dir |= d;   3: m_dir &= ~d;
          4: m_en |= d;    5: m_en &= ~d;
          6: m_edge |= d;  7: m_edge &= ~d;
          8: m_pol |= d;   9: m_pol &= ~d;
          10: m_any |= d;  11: m_any &= ~d;
          13: m_loop = d[0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge pclk) begin
    if (presetn && hist.size() == 3) begin
      chk("R5 irq", 32'(irq), 32'(|(m_status() & m_en)));
      chk("R2 pin_out", 32'(pin_out), 32'(m_out));
      chk("R4 pin_oe", 32'(pin_oe), 32'(m_dir));
    end
  end

  task automatic wr(int w, logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = 6'(w * 4); pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(int w, output logic [31:0] v);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = 6'(w * 4);
    @(negedge pclk); penable = 1;
    #1 v = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic rdchk(string tag, int w);
    logic [31:0] v;
    rd(w, v);
    chk(tag, v, m_read(w));
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge pclk);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge pclk);
    presetn = 1;
    settle(1);
    chk("R1 pin_oe reset", 32'(pin_oe), 0);
    chk("R1 irq reset", 32'(irq), 0);
    rd(13, v); chk("R1 control reset", v, 0);
    rd(1, v);  chk("R6 reset level status all ones", v, 32'hFF);

    wr(0, 32'hA5); chk("R2 set out", 32'(pin_out), 32'hA5);
    wr(1, 32'h05); chk("R3 clear out", 32'(pin_out), 32'hA0);
    wr(2, 32'hF0); chk("R4 dir out", 32'(pin_oe), 32'hF0);
    wr(3, 32'h30); chk("R4 dir in", 32'(pin_oe), 32'hC0);
    rdchk("R4 dir readback", 2);

    pin_in = 8'h3C; settle(3);
    rd(0, v); chk("R2 sync input", v, 32'h3C);
    pin_in = 8'h00; settle(3);

    wr(6, 32'h0F); rdchk("R6 edge readback", 6);
    wr(8, 32'h11); rdchk("R7 polarity readback", 9);
    wr(10, 32'h04); rdchk("R8 anyedge readback", 11);
    wr(4, 32'h0F); rdchk("R5 enable readback", 5);
    chk("R5 irq quiet", 32'(irq), 0);

    pin_in = 8'h03; settle(4);
    rd(1, v); chk("R7 rising pin0 latched", v & 32'h3, 32'h1);
    pin_in = 8'h01; settle(4);
    rd(1, v); chk("R7 falling pin1 latched", v & 32'h2, 32'h2);
    pin_in = 8'h05; settle(4);
    rd(1, v); chk("R8 anyedge pin2 rise", v & 32'h4, 32'h4);
    chk("R5 irq asserted", 32'(irq), 1);

    wr(12, 32'h07); settle(1);
    rd(1, v); chk("R9 latch cleared", v & 32'hF, 0);
    rdchk("R9 clear word reads zero", 12);
    pin_in = 8'h01; settle(4);
    rd(1, v); chk("R8 anyedge pin2 fall", v & 32'h4, 32'h4);
    wr(12, 32'h04);

    wr(4, 32'h30);
    pin_in = 8'h11; settle(3);
    rd(1, v); chk("R6 level high pin4", v & 32'h30, 32'h30);
    pin_in = 8'h21; settle(3);
    rd(1, v); chk("R6 level not latched", v & 32'h30, 32'h00);
    wr(5, 32'hFF); settle(1);
    chk("R5 disabled irq", 32'(irq), 0);
    wr(4, 32'h30); wr(7, 32'h01); rdchk("R6 level word", 7);

    wr(13, 32'h1); pin_in = 8'h5A; settle(3);
    rd(0, v); chk("R10 loopback input", v, 32'hA0);
    wr(0, 32'h03); settle(3);
    rd(0, v); chk("R10 loopback follows out", v, 32'hA3);
    wr(13, 32'h0); settle(3);
    rd(0, v); chk("R10 normal input", v, 32'h5A);
    rdchk("R10 control readback", 13);

    wr(11, 32'h04); wr(9, 32'hFF); rdchk("R7 polarity cleared", 8);
    settle(5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule